// File: doc/BRIEF.md
# Single-Pair Ethernet Link Startup Controller

This block is the control state machine that brings a full-duplex single-pair 100 Mbit/s link into service. One PHY on the pair is strapped as master and the other as slave. The controller decides when its own transmitter is silent, when it sends idle symbols and when it may carry data. The receiver itself is outside the block: it reports its status on three plain inputs. These are a local receiver-OK flag, the receiver-OK flag reported by the far end, and a flag that the receiver has synchronised to the incoming idle stream.

The startup handshake is not the same on the two sides. Once it is enabled, the master starts training by itself. The slave keeps quiet until it has locked to the master's idle stream, and only then does it start training. On each side, training lasts a fixed minimum number of cycles, counted by a timer that the block owns. The master moves to data mode only when both its own receiver and the far receiver report OK. The slave needs only the far (master) receiver to report OK. A link-up flag follows the data state. Clearing the enable bit, or losing the local receiver while the link is up, takes the link down.

Top module: `sp_link_ctrl`

## Requirements
- R1: After reset the state output is 0 (disabled), the transmit mode is 0 (silent) and link-up is low.
- R2: When `link_en` is low at a clock edge, the state becomes 0 at that edge from any state, with transmit mode 0 and link-up low.
- R3: A master (`is_master` high) in state 0 with `link_en` high enters state 2 (training) at the next edge and transmits idle (transmit mode 1).
- R4: A slave in state 0 with `link_en` high enters state 1 (waiting for sync) with transmit mode 0. It stays in state 1 while `rx_synced` is low, and enters state 2 at the first edge where `rx_synced` is high.
- R5: On every entry into state 2, the minimum-wait timer restarts. The block stays in state 2 for exactly `MINWAIT_CYC` cycles, then enters state 3 (send idle, transmit mode 1).
- R6: A master in state 3 moves to state 4 (send idle-or-data) only at an edge where `loc_rcvr_ok` and `rem_rcvr_ok` are both high. A single OK flag on its own keeps it in state 3.
- R7: A slave in state 3 moves to state 4 at the first edge where `rem_rcvr_ok` is high, whatever the value of `loc_rcvr_ok`.
- R8: `link_up` is high, and the transmit mode is 2 (idle-or-data), exactly while the state is 4.
- R9: In state 4, an edge with `loc_rcvr_ok` low returns the block to state 2 and drops `link_up`.
- R10: A master and a slave connected back to back pass through their states in this order: master 0,2,3,4 and slave 0,1,2,3,4. Both end with link-up high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link-control enable bit |
| is_master | input | 1 | Role strap: 1 for master, 0 for slave |
| loc_rcvr_ok | input | 1 | Local receiver status OK |
| rem_rcvr_ok | input | 1 | Far-end receiver status OK |
| rx_synced | input | 1 | Receiver locked to the incoming idle stream |
| tx_mode | output | 2 | 0 silent, 1 send idle, 2 send idle-or-data |
| link_up | output | 1 | Link established; data traffic allowed |
| state | output | 3 | 0 disabled, 1 wait sync, 2 training, 3 send idle, 4 send data |

## Verification
The assertions assume that `is_master` is a strap and does not change while the link is enabled. They also assume that the status inputs are synchronous to `clk`. They assume nothing about the order in which the status flags arrive. The bench changes `is_master` only by instantiating two copies with fixed straps. It drives every status input at the falling clock edge, either from a directed task or from a lock model. The lock model raises the receiver flags a few cycles after the other side starts transmitting, and clears them when that side goes silent.

// File: rtl/sp_link_pkg.sv
package sp_link_pkg;

  typedef enum logic [2:0] {
    LS_DISABLED  = 3'd0,
    LS_WAIT_SYNC = 3'd1,
    LS_TRAINING  = 3'd2,
    LS_SEND_IDLE = 3'd3,
    LS_SEND_DATA = 3'd4
  } link_state_e;

  typedef enum logic [1:0] {
    TXM_SILENT    = 2'd0,
    TXM_IDLE      = 2'd1,
    TXM_IDLE_DATA = 2'd2
  } tx_mode_e;

  localparam int unsigned STATE_W = 3;
  localparam int unsigned TXM_W   = 2;

endpackage

// File: rtl/sp_minwait_timer.sv
module sp_minwait_timer #(
  parameter int unsigned MINWAIT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = (MINWAIT_CYC < 2) ? 1 : $clog2(MINWAIT_CYC);
  localparam logic [CW-1:0] LAST = CW'(MINWAIT_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == LAST);

  // Count while running; hold on expiry; clear on each fresh entry.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart)          cnt_q <= '0;
    else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sp_link_fsm.sv
module sp_link_fsm
  import sp_link_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        link_en,
  input  logic        is_master,
  input  logic        loc_rcvr_ok,
  input  logic        rem_rcvr_ok,
  input  logic        rx_synced,
  input  logic        timer_done,
  output link_state_e state_q,
  output logic        timer_restart,
  output logic        timer_run
);
  link_state_e state_d;
  logic        data_gate;

  // Master needs both receivers healthy; slave only needs the far end.
  assign data_gate = is_master ? (loc_rcvr_ok && rem_rcvr_ok) : rem_rcvr_ok;

  always_comb begin
    state_d = state_q;
    if (!link_en) begin
      state_d = LS_DISABLED;
    end else begin
      case (state_q)
        LS_DISABLED:  state_d = is_master ? LS_TRAINING : LS_WAIT_SYNC;
        LS_WAIT_SYNC: if (rx_synced)    state_d = LS_TRAINING;
        LS_TRAINING:  if (timer_done)   state_d = LS_SEND_IDLE;
        LS_SEND_IDLE: if (data_gate)    state_d = LS_SEND_DATA;
        LS_SEND_DATA: if (!loc_rcvr_ok) state_d = LS_TRAINING;
        default:                        state_d = LS_DISABLED;
      endcase
    end
  end

  assign timer_restart = (state_d == LS_TRAINING) && (state_q != LS_TRAINING);
  assign timer_run     = (state_q == LS_TRAINING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LS_DISABLED;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/sp_link_txdec.sv
module sp_link_txdec
  import sp_link_pkg::*;
(
  input  link_state_e state_q,
  output tx_mode_e    tx_mode,
  output logic        link_up
);
  always_comb begin
    case (state_q)
      LS_TRAINING,
      LS_SEND_IDLE: tx_mode = TXM_IDLE;
      LS_SEND_DATA: tx_mode = TXM_IDLE_DATA;
      default:      tx_mode = TXM_SILENT;
    endcase
  end

  assign link_up = (state_q == LS_SEND_DATA);
endmodule

// File: rtl/sp_link_ctrl.sv
module sp_link_ctrl
  import sp_link_pkg::*;
#(
  parameter int unsigned MINWAIT_CYC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_en,
  input  logic               is_master,
  input  logic               loc_rcvr_ok,
  input  logic               rem_rcvr_ok,
  input  logic               rx_synced,
  output logic [TXM_W-1:0]   tx_mode,
  output logic               link_up,
  output logic [STATE_W-1:0] state
);
  link_state_e st;
  tx_mode_e    txm;
  logic        t_restart, t_run, t_done;

  sp_minwait_timer #(.MINWAIT_CYC(MINWAIT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (t_restart),
    .run     (t_run),
    .expired (t_done)
  );

  sp_link_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .link_en       (link_en),
    .is_master     (is_master),
    .loc_rcvr_ok   (loc_rcvr_ok),
    .rem_rcvr_ok   (rem_rcvr_ok),
    .rx_synced     (rx_synced),
    .timer_done    (t_done),
    .state_q       (st),
    .timer_restart (t_restart),
    .timer_run     (t_run)
  );

  sp_link_txdec u_dec (
    .state_q (st),
    .tx_mode (txm),
    .link_up (link_up)
  );

  assign tx_mode = txm;
  assign state   = st;
endmodule

// File: rtl/sp_link_ctrl_chk.sv
module sp_link_ctrl_chk
  import sp_link_pkg::*;
#(
  parameter int unsigned MINWAIT_CYC = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               link_en,
  input logic               is_master,
  input logic               loc_rcvr_ok,
  input logic               rem_rcvr_ok,
  input logic               rx_synced,
  input logic [TXM_W-1:0]   tx_mode,
  input logic               link_up,
  input logic [STATE_W-1:0] state
);
  localparam int unsigned RW = $clog2(MINWAIT_CYC + 2);
  localparam logic [RW-1:0] RMAX = RW'(MINWAIT_CYC + 1);

  logic [RW-1:0] trn_run;

  // Independent count of consecutive cycles spent in training.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      trn_run <= '0;
    else if (state != LS_TRAINING)   trn_run <= '0;
    else if (trn_run != RMAX)        trn_run <= trn_run + 1'b1;
  end

  assert_disable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !link_en |=> (state == LS_DISABLED) && (tx_mode == TXM_SILENT) && !link_up);

  assert_master_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && link_en && (state == LS_DISABLED) |=> (state == LS_TRAINING));

  assert_slave_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && link_en && !rx_synced && (state == LS_WAIT_SYNC) |=> (state == LS_WAIT_SYNC));

  assert_minwait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LS_SEND_IDLE) && ($past(state) == LS_TRAINING) |-> (trn_run == RW'(MINWAIT_CYC)));

  assert_master_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_master && link_en && (state == LS_SEND_IDLE) && !(loc_rcvr_ok && rem_rcvr_ok)
      |=> (state == LS_SEND_IDLE));

  assert_slave_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master && link_en && rem_rcvr_ok && (state == LS_SEND_IDLE) |=> (state == LS_SEND_DATA));

  assert_linkup_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> ($past(state) == LS_SEND_IDLE));

  assert_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link_en && !loc_rcvr_ok && (state == LS_SEND_DATA) |=> (state == LS_TRAINING) && !link_up);
endmodule

bind sp_link_ctrl sp_link_ctrl_chk #(.MINWAIT_CYC(MINWAIT_CYC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_en     (link_en),
  .is_master   (is_master),
  .loc_rcvr_ok (loc_rcvr_ok),
  .rem_rcvr_ok (rem_rcvr_ok),
  .rx_synced   (rx_synced),
  .tx_mode     (tx_mode),
  .link_up     (link_up),
  .state       (state)
);

// File: tb/test_sp_link_ctrl.sv
`timescale 1ns/1ps
module test_sp_link_ctrl;
  localparam int MW = 12;
  localparam int LOCK_DLY = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // manual stimulus shared by both sides
  logic man_en = 0, man_loc = 0, man_rem = 0, man_sync = 0;
  logic auto_md = 0;

  // lock model
  int   m_cnt = 0, s_cnt = 0;
  logic m_lock, s_lock;
  assign m_lock = (m_cnt >= LOCK_DLY);
  assign s_lock = (s_cnt >= LOCK_DLY);

  logic       m_loc, m_rem, m_sync, s_loc, s_rem, s_sync;
  logic [1:0] m_tx, s_tx;
  logic       m_up, s_up;
  logic [2:0] m_st, s_st;

  assign m_loc  = auto_md ? m_lock : man_loc;
  assign m_rem  = auto_md ? s_lock : man_rem;
  assign m_sync = auto_md ? m_lock : man_sync;
  assign s_loc  = auto_md ? s_lock : man_loc;
  assign s_rem  = auto_md ? m_lock : man_rem;
  assign s_sync = auto_md ? s_lock : man_sync;

  sp_link_ctrl #(.MINWAIT_CYC(MW)) i_sp_link_ctrl (
    .clk(clk), .rst_n(rst_n), .link_en(man_en), .is_master(1'b1),
    .loc_rcvr_ok(m_loc), .rem_rcvr_ok(m_rem), .rx_synced(m_sync),
    .tx_mode(m_tx), .link_up(m_up), .state(m_st));

  sp_link_ctrl #(.MINWAIT_CYC(MW)) i_sp_link_ctrl_s (
    .clk(clk), .rst_n(rst_n), .link_en(man_en), .is_master(1'b0),
    .loc_rcvr_ok(s_loc), .rem_rcvr_ok(s_rem), .rx_synced(s_sync),
    .tx_mode(s_tx), .link_up(s_up), .state(s_st));

  // Each receiver locks after the far transmitter has been active LOCK_DLY cycles.
  always @(negedge clk) begin
    if (s_tx != 2'd0) m_cnt <= (m_cnt < 100) ? m_cnt + 1 : m_cnt; else m_cnt <= 0;
    if (m_tx != 2'd0) s_cnt <= (s_cnt < 100) ? s_cnt + 1 : s_cnt; else s_cnt <= 0;
  end

  // state transition logs
  logic logging = 0;
  int m_log[16], s_log[16];
  int m_n = 0, s_n = 0;
  logic [2:0] m_last = 0, s_last = 0;
  always @(negedge clk) begin
    if (logging) begin
      if (m_st != m_last) begin if (m_n < 16) m_log[m_n] = int'(m_st); m_n++; m_last = m_st; end
      if (s_st != s_last) begin if (s_n < 16) s_log[s_n] = int'(s_st); s_n++; s_last = s_st; end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; man_en = 0; man_loc = 0; man_rem = 0; man_sync = 0; auto_md = 0;
    tick(3);
    rst_n = 1;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 master state", int'(m_st), 0);
    chk("R1 master tx", int'(m_tx), 0);
    chk("R1 master link_up", int'(m_up), 0);
    chk("R1 slave state", int'(s_st), 0);
  endtask

  task automatic t_master_path();
    do_reset();
    man_en = 1;
    tick(1);
    chk("R3 master training", int'(m_st), 2);
    chk("R3 master tx idle", int'(m_tx), 1);
    chk("R4 slave wait sync", int'(s_st), 1);
    chk("R4 slave silent", int'(s_tx), 0);
    tick(MW - 1);
    chk("R5 master still training", int'(m_st), 2);
    tick(1);
    chk("R5 master send idle", int'(m_st), 3);
    man_loc = 1; man_rem = 0;
    tick(3);
    chk("R6 master local only", int'(m_st), 3);
    man_loc = 0; man_rem = 1;
    tick(3);
    chk("R6 master remote only", int'(m_st), 3);
    chk("R4 slave holds without sync", int'(s_st), 1);
    man_loc = 1; man_rem = 1;
    tick(1);
    chk("R6 master data", int'(m_st), 4);
    chk("R8 master link_up", int'(m_up), 1);
    chk("R8 master tx data", int'(m_tx), 2);
    man_sync = 1;
    tick(1);
    chk("R4 slave training on sync", int'(s_st), 2);
    man_en = 0;
    tick(1);
    chk("R2 master disabled", int'(m_st), 0);
    chk("R2 master silent", int'(m_tx), 0);
    chk("R2 master link down", int'(m_up), 0);
    chk("R2 slave disabled", int'(s_st), 0);
  endtask

  task automatic t_slave_path();
    do_reset();
    man_en = 1; man_sync = 1; man_loc = 1; man_rem = 0;
    tick(1);
    chk("R4 slave wait sync", int'(s_st), 1);
    tick(1);
    chk("R4 slave training", int'(s_st), 2);
    tick(MW - 1);
    chk("R5 slave still training", int'(s_st), 2);
    tick(1);
    chk("R5 slave send idle", int'(s_st), 3);
    tick(3);
    chk("R7 slave waits remote", int'(s_st), 3);
    man_loc = 0; man_rem = 1;
    tick(1);
    chk("R7 slave data on remote", int'(s_st), 4);
    chk("R8 slave link_up", int'(s_up), 1);
    chk("R8 slave tx data", int'(s_tx), 2);
    tick(1);
    chk("R9 slave back to training", int'(s_st), 2);
    chk("R9 slave link down", int'(s_up), 0);
    tick(MW - 1);
    chk("R5 restart still training", int'(s_st), 2);
    tick(1);
    chk("R5 restart send idle", int'(s_st), 3);
    man_en = 0;
    tick(1);
    chk("R2 slave disabled", int'(s_st), 0);
  endtask

  task automatic t_back_to_back();
    do_reset();
    m_n = 0; s_n = 0; m_last = 0; s_last = 0;
    logging = 1;
    auto_md = 1;
    tick(1);
    man_en = 1;
    tick(4 * MW + 20);
    logging = 0;
    chk("R10 master transitions", m_n, 3);
    chk("R10 slave transitions", s_n, 4);
    if (m_n == 3) begin
      chk("R10 master 1st", m_log[0], 2);
      chk("R10 master 2nd", m_log[1], 3);
      chk("R10 master 3rd", m_log[2], 4);
    end
    if (s_n == 4) begin
      chk("R10 slave 1st", s_log[0], 1);
      chk("R10 slave 2nd", s_log[1], 2);
      chk("R10 slave 3rd", s_log[2], 3);
      chk("R10 slave 4th", s_log[3], 4);
    end
    chk("R10 master link_up", int'(m_up), 1);
    chk("R10 slave link_up", int'(s_up), 1);
  endtask

  initial begin
    t_reset();
    t_master_path();
    t_slave_path();
    t_back_to_back();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule